// File: doc/BRIEF.md
# Device lifecycle state controller

This block tracks the security lifecycle of a chip. There are three states: open, closed and return-for-analysis (RMA). A one-time-programmable closed bit selects between open and closed. Two stored 15-bit passwords, together with a debug-port request, move a closed device into RMA and then back to closed. The block derives several policy outputs from the current state: whether authentication is mandatory, whether the first-stage loader may start given the authentication result, whether engineering boot is allowed, and whether test access or user secret fuses are reachable.

RMA can be entered only once. A sticky "RMA used" flag records the entry. That flag stands for a fuse, so only a reset of the fuse model, which is the block reset `rst_n`, clears it. A request whose password is wrong, or whose type does not fit the current state, leaves the state unchanged. Such a request produces a one-cycle error pulse in the cycle after the request.

Top module: `lifecycle_ctrl`

## Requirements
- R1: After reset with `otp_closed`=0, `state` is 0 (open), `rma_used` is 0 and `req_err` is 0.
- R2: `state` encodes open as 0, closed as 1 and RMA as 2. Outside RMA, `state` is 1 when `otp_closed`=1 and 0 otherwise. `auth_required` is 1 exactly when `state` is 1.
- R3: In the open state, `boot_ok` equals `auth_done`, whatever the value of `auth_ok`.
- R4: In the closed state, `boot_ok` equals `auth_done` AND `auth_ok`.
- R5: An unlock request is `req_valid`=1 with `req_relock`=0. It takes effect when the state is closed, `rma_used` is 0 and `req_pw` equals `pw_unlock`. In the next cycle `state` is 2 and `rma_used` is 1.
- R6: A relock request is `req_valid`=1 with `req_relock`=1. It takes effect when the state is RMA and `req_pw` equals `pw_relock`. In the next cycle the state is no longer RMA.
- R7: Once `rma_used` is 1, it stays 1 until reset. An unlock request with the correct password is then refused.
- R8: Any request that does not take effect leaves `state` unchanged. It sets `req_err` to 1 for exactly the following cycle. A request that takes effect leaves `req_err` at 0.
- R9: In RMA, `test_en`=1, `boot_ok`=0 and `secret_en`=0. Outside RMA, `test_en`=0 and `secret_en`=1.
- R10: `eng_boot_en` is 1 only in the open state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also resets the fuse model |
| otp_closed | input | 1 | One-time-programmable closed bit |
| pw_unlock | input | 15 | Stored unlock password |
| pw_relock | input | 15 | Stored relock password |
| req_valid | input | 1 | Debug-port request strobe |
| req_relock | input | 1 | Request type: 0 unlock, 1 relock |
| req_pw | input | 15 | Password supplied with the request |
| auth_done | input | 1 | Authentication has completed |
| auth_ok | input | 1 | Authentication result |
| state | output | 2 | Lifecycle state: 0 open, 1 closed, 2 RMA |
| auth_required | output | 1 | Authentication is mandatory |
| boot_ok | output | 1 | Loader start permitted |
| eng_boot_en | output | 1 | Engineering boot allowed |
| test_en | output | 1 | Test access enabled |
| secret_en | output | 1 | User secret fuse access allowed |
| req_err | output | 1 | One-cycle pulse for a refused request |
| rma_used | output | 1 | Sticky flag: RMA has been entered |

## Verification
The bench attacks the single-entry rule by relocking and then presenting the correct unlock password again. A design that forgot the sticky flag would re-enter RMA at that point. It also sends requests of the wrong type for the current state, such as a relock while closed or an unlock while in RMA or open. A design that checked only the password would change state on these, or would raise no error pulse. Failed authentication is exercised in both open and closed states. A design with the policy inverted would block boot on an open part or let a closed part boot. Random traffic also toggles the closed bit while in RMA, which must not pull the device out of RMA.

// File: rtl/lifecycle_ctrl.sv
module lifecycle_ctrl #(
  parameter int PW_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            otp_closed,
  input  logic [PW_W-1:0] pw_unlock,
  input  logic [PW_W-1:0] pw_relock,
  input  logic            req_valid,
  input  logic            req_relock,
  input  logic [PW_W-1:0] req_pw,
  input  logic            auth_done,
  input  logic            auth_ok,
  output logic [1:0]      state,
  output logic            auth_required,
  output logic            boot_ok,
  output logic            eng_boot_en,
  output logic            test_en,
  output logic            secret_en,
  output logic            req_err,
  output logic            rma_used
);
  localparam logic [1:0] ST_OPEN   = 2'd0;
  localparam logic [1:0] ST_CLOSED = 2'd1;
  localparam logic [1:0] ST_RMA    = 2'd2;

  logic in_rma, used_q, err_q;
  logic unlock_hit, relock_hit;

  assign state = in_rma ? ST_RMA : (otp_closed ? ST_CLOSED : ST_OPEN);

  assign unlock_hit = req_valid && !req_relock && (state == ST_CLOSED)
                      && !used_q && (req_pw == pw_unlock);
  assign relock_hit = req_valid && req_relock && in_rma && (req_pw == pw_relock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rma <= 1'b0;
      used_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= req_valid && !(unlock_hit || relock_hit);
      if (unlock_hit) begin
        in_rma <= 1'b1;
        used_q <= 1'b1;
      end else if (relock_hit) begin
        in_rma <= 1'b0;
      end
    end
  end

  assign auth_required = (state == ST_CLOSED);
  assign boot_ok       = (state == ST_OPEN)   ? auth_done :
                         (state == ST_CLOSED) ? (auth_done && auth_ok) : 1'b0;
  assign eng_boot_en   = (state == ST_OPEN);
  assign test_en       = in_rma;
  assign secret_en     = !in_rma;
  assign req_err       = err_q;
  assign rma_used      = used_q;

  // R5: RMA is entered only from closed with the flag still clear
  a_r5_rma_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_rma) |-> ($past(state) == ST_CLOSED) && !$past(used_q));

  // R7: the used flag never clears
  a_r7_used_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    used_q |=> used_q);

  // R8: a wrong password changes nothing and pulses the error
  a_r8_bad_pw: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_relock ? (req_pw != pw_relock) : (req_pw != pw_unlock)))
    |=> req_err && $stable(in_rma));

  // R8: an error only follows a request
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid));

  // R9: no boot and no secrets while in RMA
  a_r9_rma_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RMA) |-> !boot_ok && !secret_en && test_en);

  // R10: engineering boot only on an open part
  a_r10_eng_open: assert property (@(posedge clk) disable iff (!rst_n)
    eng_boot_en |-> !otp_closed && !test_en);
endmodule

// File: tb/tb_lifecycle_ctrl.sv
`timescale 1ns/100ps
module tb_lifecycle_ctrl;
  localparam logic [14:0] PWU = 15'h2A5C;
  localparam logic [14:0] PWR = 15'h51E3;

  logic clk = 0, rst_n = 0, otp_closed = 0;
  logic req_valid = 0, req_relock = 0, auth_done = 0, auth_ok = 0;
  logic [14:0] req_pw = 0;
  logic [1:0] state;
  logic auth_required, boot_ok, eng_boot_en, test_en, secret_en, req_err, rma_used;

  int tests = 0, fails = 0;
  bit m_rma, m_used, m_err, done = 0;

  always #2.5 clk = ~clk;

  lifecycle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .otp_closed(otp_closed),
    .pw_unlock(PWU), .pw_relock(PWR),
    .req_valid(req_valid), .req_relock(req_relock), .req_pw(req_pw),
    .auth_done(auth_done), .auth_ok(auth_ok),
    .state(state), .auth_required(auth_required), .boot_ok(boot_ok),
    .eng_boot_en(eng_boot_en), .test_en(test_en), .secret_en(secret_en),
    .req_err(req_err), .rma_used(rma_used));

  function automatic logic [1:0] m_state();
    return m_rma ? 2'd2 : (otp_closed ? 2'd1 : 2'd0);
  endfunction

  function automatic bit m_boot();
    case (m_state())
      2'd0:    return auth_done;
      2'd1:    return auth_done && auth_ok;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2/R5/R6/R7 state", state, m_state());
    chk("R2 auth_required", auth_required, m_state() == 2'd1);
    chk("R3/R4/R9 boot_ok", boot_ok, m_boot());
    chk("R10 eng_boot_en", eng_boot_en, m_state() == 2'd0);
    chk("R9 test_en", test_en, m_rma);
    chk("R9 secret_en", secret_en, !m_rma);
    chk("R8 req_err", req_err, m_err);
    chk("R7 rma_used", rma_used, m_used);
  endtask

  task automatic step(input bit v, input bit rl, input logic [14:0] pw,
                      input bit cl, input bit ad, input bit ao);
    bit ok_u, ok_r;
    @(negedge clk);
    req_valid = v; req_relock = rl; req_pw = pw;
    otp_closed = cl; auth_done = ad; auth_ok = ao;
    @(posedge clk);
    ok_u = v && !rl && m_state() == 2'd1 && !m_used && pw == PWU;
    ok_r = v && rl && m_rma && pw == PWR;
    m_err = v && !(ok_u || ok_r);
    if (ok_u) begin m_rma = 1; m_used = 1; end
    else if (ok_r) m_rma = 0;
    #1 check_all();
  endtask

  task automatic do_reset(input bit cl);
    @(negedge clk);
    rst_n = 0; req_valid = 0; otp_closed = cl;
    repeat (2) @(negedge clk);
    m_rma = 0; m_used = 0; m_err = 0;
    rst_n = 1;
    #1 check_all();
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(0);
    // R1 reset state
    chk("R1 state", state, 0);
    chk("R1 rma_used", rma_used, 0);
    chk("R1 req_err", req_err, 0);
    // R3 open: failed auth still boots
    step(0, 0, 0, 0, 1, 0);
    chk("R3 open boot with failed auth", boot_ok, 1);
    // R8 unlock in open refused
    step(1, 0, PWU, 0, 0, 0);
    chk("R8 unlock refused in open", req_err, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R8 error lasts one cycle", req_err, 0);
    // R4 closed blocks failed auth
    step(0, 0, 0, 1, 1, 0);
    chk("R4 closed blocks failed auth", boot_ok, 0);
    step(0, 0, 0, 1, 1, 1);
    chk("R4 closed boots with good auth", boot_ok, 1);
    // R8 wrong unlock password
    step(1, 0, PWU ^ 15'h1, 1, 0, 0);
    chk("R8 wrong password keeps closed", state, 1);
    // R6 relock in closed refused
    step(1, 1, PWR, 1, 0, 0);
    chk("R8 relock refused in closed", req_err, 1);
    // R5 enter RMA
    step(1, 0, PWU, 1, 1, 1);
    chk("R5 enters RMA", state, 2);
    chk("R5 sets used flag", rma_used, 1);
    chk("R9 no boot in RMA", boot_ok, 0);
    chk("R9 test access in RMA", test_en, 1);
    // R9 closed bit cleared while in RMA
    step(0, 0, 0, 0, 1, 1);
    chk("R9 stays RMA with closed bit low", state, 2);
    chk("R10 no eng boot in RMA", eng_boot_en, 0);
    // R8 wrong relock password
    step(1, 1, PWR ^ 15'h4000, 1, 0, 0);
    chk("R8 wrong relock keeps RMA", state, 2);
    // R6 relock
    step(1, 1, PWR, 1, 0, 0);
    chk("R6 relock to closed", state, 1);
    chk("R6 no error on relock", req_err, 0);
    // R7 second unlock refused
    step(1, 0, PWU, 1, 0, 0);
    chk("R7 second unlock refused", state, 1);
    chk("R7 error on second unlock", req_err, 1);

    // random traffic with periodic fuse-model resets
    for (int i = 0; i < 3000; i++) begin
      bit v, rl, good;
      logic [14:0] pw;
      if (i % 400 == 0) do_reset($urandom_range(0, 1));
      v = ($urandom_range(0, 3) == 0);
      rl = $urandom_range(0, 1);
      good = $urandom_range(0, 1);
      pw = good ? (rl ? PWR : PWU) : 15'($urandom);
      step(v, rl, pw, ($urandom_range(0, 7) != 0), $urandom_range(0, 1),
           $urandom_range(0, 1));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule